// File: doc/BRIEF.md
# MII Transmit Frame Generator

This block turns a start pulse, two 48-bit station addresses, a 16-bit length/type value and a stream of payload bytes into a complete Ethernet frame. The frame goes out on a 4-bit media-independent interface, one nibble per clock, which gives 100 Mb/s at a 25 MHz line clock. The generator adds the preamble and start delimiter itself. It serialises the header and pulls payload bytes through a ready/valid handshake. Short payloads are padded with zero bytes, and the CRC-32 frame check sequence is computed nibble by nibble as the data leaves. After each frame the block keeps the line quiet for a programmable interframe gap before it takes the next start.

The address and length inputs are captured on the clock edge that accepts the start pulse, so they may change afterwards. The payload source is expected to hold valid high whenever ready is high. If no byte is offered in such a cycle, a zero byte goes out in its place, because the line cannot pause mid-frame.

Top module: `mii_frame_tx`

## Requirements
- R1: Every byte leaves as two nibbles on consecutive clocks: bits 3:0 first, then bits 7:4, with one nibble per clock and no idle cycle inside a frame.
- R2: A frame opens with fifteen nibbles of 0x5 and then one nibble of 0xD. This is seven 0x55 bytes and the 0xD5 delimiter.
- R3: After the delimiter come dst_i (byte 47:40 first, down to 7:0), then src_i in the same byte order, then len_i high byte then low byte.
- R4: The last four bytes are the complement of the reflected CRC-32 (polynomial 0x04C11DB7, preset to all ones). It covers header, payload and pad but not preamble or delimiter, and is sent least significant byte first. For a broadcast destination, source 58:00:E3:5B:E8:41, length 0x002E and the 46 payload bytes 01..09,10..19,20..29,30..39,40..46, these bytes are CF C7 1F CC.
- R5: A payload shorter than 46 bytes is followed by 0x00 bytes until 46 bytes have been sent. A payload of 46 bytes or more gets no pad.
- R6: mii_txen_o is high in one unbroken run from the first preamble nibble to the last check-sequence nibble. Whenever it is low, mii_txd_o is 0.
- R7: A start accepted on a clock edge puts the first preamble nibble on the outputs immediately after that edge.
- R8: After the last check-sequence nibble, mii_txen_o stays low for at least 24 clocks. A start that is waiting is accepted so that the gap is exactly 24 clocks.
- R9: pay_ready_o is high only in the payload phase, once per byte, in the clock that emits that byte's low nibble. A byte is taken when ready and valid are both high. The byte taken with pay_last_i high ends the payload, so exactly the offered number of bytes is accepted.
- R10: A start pulse arriving while busy_o is high, inside the frame or inside the gap, has no effect, and no frame follows from it later.
- R11: busy_o is low after reset and rises with the first preamble nibble. It stays high through the frame and the gap and is low when the next start can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to send one frame |
| dst_i | input | 48 | Destination address, captured at start |
| src_i | input | 48 | Source address, captured at start |
| len_i | input | 16 | Length/type value, captured at start |
| pay_data_i | input | 8 | Payload byte |
| pay_valid_i | input | 1 | Payload byte present |
| pay_last_i | input | 1 | Marks the final payload byte |
| pay_ready_o | output | 1 | Block takes the offered byte this clock |
| mii_txd_o | output | 4 | Transmit nibble |
| mii_txen_o | output | 1 | Transmit enable / data valid |
| busy_o | output | 1 | Frame or gap in progress |

## Verification
Each output nibble is registered on the edge that decides it. The first preamble nibble is therefore visible just after the edge that samples start_i, and the n-th frame nibble follows n-1 edges later. pay_ready_o is decoded from registered state, so it is valid for the whole cycle before the edge that takes the byte. The bench drives inputs one time unit after the rising edge and reads the handshake at that point. It captures nibbles, txd-zero and busy conditions on the falling edge, and it measures the gap as the number of falling edges with enable low between two frames. Frames are compared nibble by nibble against a byte image built in the bench, including a bench-side CRC-32, across payload lengths 1 to 60 and 100, with one frame checked against the literal check bytes CF C7 1F CC.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_HDR,
      ST_PAY,
      ST_PAD,
      ST_FCS,
      ST_GAP
   } tx_state_e;

   localparam int HDR_BYTES = 14;
   localparam int FCS_BYTES = 4;
   localparam logic [3:0] NIB_PRE = 4'h5;
   localparam logic [3:0] NIB_SFD = 4'hD;
   localparam logic [31:0] CRC32_REFL = 32'hEDB88320;
endpackage

// File: rtl/mii_tx_crc.sv
module mii_tx_crc #(
   parameter int W = 32,
   parameter logic [W-1:0] POLY = mii_tx_pkg::CRC32_REFL,
   parameter int NB = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_i,
   input  logic          upd_i,
   input  logic          shift_i,
   input  logic [NB-1:0] nib_i,
   output logic [NB-1:0] fcs_nib_o
);
   logic [W-1:0] crc_q;
   logic [W-1:0] step;
   logic         fb;

   generate
      if (W % NB != 0) begin : g_bad_width
         $error("mii_tx_crc: W must be a multiple of NB");
      end
   endgenerate

   // LSB-first serial update, unrolled over one nibble
   always_comb begin
      step = crc_q;
      fb   = 1'b0;
      for (int b = 0; b < NB; b++) begin
         fb   = step[0] ^ nib_i[b];
         step = (step >> 1) ^ (fb ? POLY : '0);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       crc_q <= '1;
      else if (init_i)  crc_q <= '1;
      else if (upd_i)   crc_q <= step;
      else if (shift_i) crc_q <= crc_q >> NB;
   end

   assign fcs_nib_o = ~crc_q[NB-1:0];
endmodule

// File: rtl/mii_tx_hdr_sel.sv
module mii_tx_hdr_sel #(
   parameter int NBYTES = 14,
   localparam int IDX_W = $clog2(2 * NBYTES)
)(
   input  logic [8*NBYTES-1:0] hdr_i,
   input  logic [IDX_W-1:0]    idx_i,
   output logic [3:0]          nib_o
);
   localparam int SLOTS = 2 ** (IDX_W - 1);

   logic [7:0] byte_a [SLOTS];
   logic [7:0] sel_b;

   generate
      if (NBYTES < 1) begin : g_bad_n
         $error("mii_tx_hdr_sel: NBYTES must be positive");
      end
      for (genvar k = 0; k < SLOTS; k++) begin : g_slot
         if (k < NBYTES) begin : g_used
            assign byte_a[k] = hdr_i[8*(NBYTES-k)-1 -: 8];
         end else begin : g_fill
            assign byte_a[k] = 8'h00;
         end
      end
   endgenerate

   always_comb begin
      sel_b = byte_a[idx_i[IDX_W-1:1]];
      nib_o = idx_i[0] ? sel_b[7:4] : sel_b[3:0];
   end
endmodule

// File: rtl/mii_frame_tx.sv
module mii_frame_tx #(
   parameter int PRE_BYTES = 8,
   parameter int MIN_PAY   = 46,
   parameter int IFG_NIBS  = 24
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic [47:0] dst_i,
   input  logic [47:0] src_i,
   input  logic [15:0] len_i,
   input  logic [7:0]  pay_data_i,
   input  logic        pay_valid_i,
   input  logic        pay_last_i,
   output logic        pay_ready_o,
   output logic [3:0]  mii_txd_o,
   output logic        mii_txen_o,
   output logic        busy_o
);
   import mii_tx_pkg::*;

   localparam int PRE_NIBS = 2 * PRE_BYTES;
   localparam int HDR_NIBS = 2 * HDR_BYTES;
   localparam int FCS_NIBS = 2 * FCS_BYTES;
   localparam int M1       = (PRE_NIBS > HDR_NIBS) ? PRE_NIBS : HDR_NIBS;
   localparam int M2       = (M1 > IFG_NIBS) ? M1 : IFG_NIBS;
   localparam int CNT_MAX  = (M2 > FCS_NIBS) ? M2 : FCS_NIBS;
   localparam int CNT_W    = $clog2(CNT_MAX + 1);
   localparam int HIDX_W   = $clog2(HDR_NIBS);
   localparam int PC_W     = $clog2(MIN_PAY + 1);

   localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_NIBS - 1);
   localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_NIBS - 1);
   localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_NIBS - 1);
   localparam logic [CNT_W-1:0] IFG_LAST = CNT_W'(IFG_NIBS - 1);
   localparam logic [PC_W-1:0]  PAY_FULL = PC_W'(MIN_PAY);

   generate
      if (PRE_BYTES < 2) begin : g_bad_pre
         $error("mii_frame_tx: PRE_BYTES must be at least 2");
      end
      if (MIN_PAY < 1) begin : g_bad_pay
         $error("mii_frame_tx: MIN_PAY must be positive");
      end
      if (IFG_NIBS < 1) begin : g_bad_ifg
         $error("mii_frame_tx: IFG_NIBS must be positive");
      end
   endgenerate

   tx_state_e             state_q, state_d;
   logic [CNT_W-1:0]      cnt_q, cnt_d;
   logic                  ph_q, ph_d;
   logic [3:0]            hold_q, hold_d;
   logic                  last_q, last_d;
   logic [PC_W-1:0]       pcnt_q, pcnt_d;
   logic [3:0]            nib_d, txd_q;
   logic                  en_d, txen_q;
   logic [8*HDR_BYTES-1:0] hdr_q;
   logic                  crc_init, crc_upd, crc_shift;
   logic [3:0]            hdr_nib, fcs_nib;

   mii_tx_hdr_sel #(.NBYTES(HDR_BYTES)) u_hdr (
      .hdr_i (hdr_q),
      .idx_i (cnt_q[HIDX_W-1:0]),
      .nib_o (hdr_nib)
   );

   mii_tx_crc #(.W(32), .POLY(CRC32_REFL), .NB(4)) u_crc (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_i    (crc_init),
      .upd_i     (crc_upd),
      .shift_i   (crc_shift),
      .nib_i     (nib_d),
      .fcs_nib_o (fcs_nib)
   );

   // next nibble and sequencing; each output nibble is registered at the edge that picks it
   always_comb begin
      state_d   = state_q;
      cnt_d     = cnt_q;
      ph_d      = ph_q;
      hold_d    = hold_q;
      last_d    = last_q;
      pcnt_d    = pcnt_q;
      nib_d     = 4'h0;
      en_d      = 1'b0;
      crc_init  = 1'b0;
      crc_upd   = 1'b0;
      crc_shift = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d  = ST_PRE;
               cnt_d    = CNT_W'(1);
               nib_d    = NIB_PRE;
               en_d     = 1'b1;
               crc_init = 1'b1;
               pcnt_d   = '0;
               ph_d     = 1'b0;
            end
         end
         ST_PRE: begin
            en_d  = 1'b1;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == PRE_LAST) begin
               nib_d   = NIB_SFD;
               state_d = ST_HDR;
               cnt_d   = '0;
            end else begin
               nib_d = NIB_PRE;
            end
         end
         ST_HDR: begin
            en_d    = 1'b1;
            nib_d   = hdr_nib;
            crc_upd = 1'b1;
            cnt_d   = cnt_q + 1'b1;
            if (cnt_q == HDR_LAST) begin
               state_d = ST_PAY;
               cnt_d   = '0;
            end
         end
         ST_PAY: begin
            en_d    = 1'b1;
            crc_upd = 1'b1;
            if (!ph_q) begin
               nib_d  = pay_valid_i ? pay_data_i[3:0] : 4'h0;
               hold_d = pay_valid_i ? pay_data_i[7:4] : 4'h0;
               last_d = pay_valid_i & pay_last_i;
               ph_d   = 1'b1;
               if (pcnt_q != PAY_FULL) pcnt_d = pcnt_q + 1'b1;
            end else begin
               nib_d = hold_q;
               ph_d  = 1'b0;
               if (last_q) state_d = (pcnt_q == PAY_FULL) ? ST_FCS : ST_PAD;
            end
         end
         ST_PAD: begin
            en_d    = 1'b1;
            crc_upd = 1'b1;
            ph_d    = ~ph_q;
            if (!ph_q) pcnt_d = pcnt_q + 1'b1;
            else if (pcnt_q == PAY_FULL) state_d = ST_FCS;
         end
         ST_FCS: begin
            en_d      = 1'b1;
            nib_d     = fcs_nib;
            crc_shift = 1'b1;
            cnt_d     = cnt_q + 1'b1;
            if (cnt_q == FCS_LAST) begin
               state_d = ST_GAP;
               cnt_d   = '0;
            end
         end
         ST_GAP: begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == IFG_LAST) begin
               state_d = ST_IDLE;
               cnt_d   = '0;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         ph_q    <= 1'b0;
         hold_q  <= '0;
         last_q  <= 1'b0;
         pcnt_q  <= '0;
         txd_q   <= '0;
         txen_q  <= 1'b0;
         hdr_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         ph_q    <= ph_d;
         hold_q  <= hold_d;
         last_q  <= last_d;
         pcnt_q  <= pcnt_d;
         txd_q   <= nib_d;
         txen_q  <= en_d;
         if (state_q == ST_IDLE && start_i) hdr_q <= {dst_i, src_i, len_i};
      end
   end

   assign pay_ready_o = (state_q == ST_PAY) && !ph_q;
   assign mii_txd_o   = txd_q;
   assign mii_txen_o  = txen_q;
   assign busy_o      = (state_q != ST_IDLE);
endmodule

// File: rtl/mii_frame_tx_chk.sv
module mii_frame_tx_chk #(
   parameter int PRE_BYTES = 8,
   parameter int MIN_PAY   = 46,
   parameter int IFG_NIBS  = 24
)(
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       pay_valid_i,
   input logic       pay_ready_o,
   input logic [3:0] mii_txd_o,
   input logic       mii_txen_o,
   input logic       busy_o
);
   localparam int MIN_NIBS = 2 * (PRE_BYTES + mii_tx_pkg::HDR_BYTES + MIN_PAY + mii_tx_pkg::FCS_BYTES);

   logic [15:0] low_cnt_q, hi_cnt_q;
   logic        seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt_q <= '0;
         hi_cnt_q  <= '0;
         seen_q    <= 1'b0;
      end else if (mii_txen_o) begin
         low_cnt_q <= '0;
         seen_q    <= 1'b1;
         if (hi_cnt_q != 16'hFFFF) hi_cnt_q <= hi_cnt_q + 1'b1;
      end else begin
         hi_cnt_q  <= '0;
         if (low_cnt_q != 16'hFFFF) low_cnt_q <= low_cnt_q + 1'b1;
      end
   end

   AST_QUIET_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !mii_txen_o |-> (mii_txd_o == 4'h0)); // R6
   AST_FRAME_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mii_txen_o) |-> (hi_cnt_q >= 16'(MIN_NIBS))); // R5
   AST_FRAME_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mii_txen_o) |-> $past(start_i)); // R7
   AST_GAP_LONG_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mii_txen_o) && seen_q) |-> (low_cnt_q >= 16'(IFG_NIBS))); // R8
   AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (pay_ready_o || (pay_ready_o && pay_valid_i)) |-> (busy_o && mii_txen_o)); // R9
   AST_TXEN_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mii_txen_o |-> busy_o); // R11
   AST_BUSY_RISES_WITH_TX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> mii_txen_o); // R11
endmodule

bind mii_frame_tx mii_frame_tx_chk #(
   .PRE_BYTES (PRE_BYTES),
   .MIN_PAY   (MIN_PAY),
   .IFG_NIBS  (IFG_NIBS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .pay_valid_i (pay_valid_i),
   .pay_ready_o (pay_ready_o),
   .mii_txd_o   (mii_txd_o),
   .mii_txen_o  (mii_txen_o),
   .busy_o      (busy_o)
);

// File: tb/tb_mii_frame_tx.sv
module tb_mii_frame_tx;
   localparam int MIN_PAY = 46;
   localparam int IFG     = 24;
   localparam int MAXN    = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [47:0] dst_i = '0;
   logic [47:0] src_i = '0;
   logic [15:0] len_i = '0;
   logic [7:0]  pay_data_i = '0;
   logic        pay_valid_i = 1'b0;
   logic        pay_last_i = 1'b0;
   wire         pay_ready_o;
   wire  [3:0]  mii_txd_o;
   wire         mii_txen_o;
   wire         busy_o;

   mii_frame_tx dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dst_i(dst_i), .src_i(src_i),
      .len_i(len_i), .pay_data_i(pay_data_i), .pay_valid_i(pay_valid_i),
      .pay_last_i(pay_last_i), .pay_ready_o(pay_ready_o), .mii_txd_o(mii_txd_o),
      .mii_txen_o(mii_txen_o), .busy_o(busy_o)
   );

   always #2 clk = ~clk;

   int n_run = 0, n_fail = 0;
   logic [3:0] cap [MAXN];
   logic [7:0] pay_mem [256];
   logic [7:0] exp_b [512];
   int cap_n = 0, acc_n = 0, fall_n = 0, rise_n = 0;
   int low_run = 0, last_gap = -1, zero_err = 0, busy_err = 0;
   logic txen_prev = 1'b0;
   bit done = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mii_txen_o) begin
            if (cap_n < MAXN) cap[cap_n] = mii_txd_o;
            cap_n++;
            if (!busy_o) busy_err++;
            if (!txen_prev) begin
               rise_n++;
               last_gap = low_run;
            end
            low_run = 0;
         end else begin
            if (mii_txd_o != 4'h0) zero_err++;
            if (txen_prev) fall_n++;
            low_run++;
         end
         if (pay_ready_o && pay_valid_i) acc_n++;
         txen_prev = mii_txen_o;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   task automatic run_frame(input logic [47:0] d, input logic [47:0] s, input logic [15:0] ln,
                            input int L, input bit poke, input bit b2b);
      int n, idx, cyc, f0, r0, e_pre, e_hdr, e_pay, e_pad, e_fcs;
      bit acc_pend;
      logic [31:0] crc, fcs;
      logic fb;
      logic [3:0] en;
      while (busy_o) begin @(posedge clk); #1; end
      cap_n = 0; acc_n = 0; f0 = fall_n; r0 = rise_n;
      dst_i = d; src_i = s; len_i = ln; start_i = 1'b1;
      idx = 0; acc_pend = 1'b0; cyc = 0;
      @(posedge clk); #1;
      start_i = 1'b0; dst_i = '0; src_i = '0; len_i = '0;
      chk(mii_txen_o === 1'b1 && mii_txd_o === 4'h5, "R7", "first nibble after start",
          {mii_txen_o, mii_txd_o}, 5'h15);
      chk(busy_o === 1'b1, "R11", "busy after start", busy_o, 1);
      while (fall_n == f0) begin
         if (acc_pend) idx++;
         pay_valid_i = (idx < L);
         pay_data_i  = pay_mem[idx[7:0]];
         pay_last_i  = (idx == L - 1);
         acc_pend    = pay_ready_o && pay_valid_i;
         start_i     = poke && (cyc == 40);
         @(posedge clk); #1;
         cyc++;
      end
      pay_valid_i = 1'b0; pay_last_i = 1'b0; start_i = 1'b0;
      // expected byte image
      n = 0;
      for (int k = 0; k < 7; k++) begin exp_b[n] = 8'h55; n++; end
      exp_b[n] = 8'hD5; n++;
      for (int k = 5; k >= 0; k--) begin exp_b[n] = d[8*k +: 8]; n++; end
      for (int k = 5; k >= 0; k--) begin exp_b[n] = s[8*k +: 8]; n++; end
      exp_b[n] = ln[15:8]; n++;
      exp_b[n] = ln[7:0]; n++;
      for (int k = 0; k < L; k++) begin exp_b[n] = pay_mem[k]; n++; end
      for (int k = L; k < MIN_PAY; k++) begin exp_b[n] = 8'h00; n++; end
      crc = 32'hFFFF_FFFF;
      for (int k = 8; k < n; k++) begin
         for (int b = 0; b < 8; b++) begin
            fb  = crc[0] ^ exp_b[k][b];
            crc = crc >> 1;
            if (fb) crc = crc ^ 32'hEDB8_8320;
         end
      end
      fcs = ~crc;
      for (int k = 0; k < 4; k++) begin exp_b[n] = fcs[8*k +: 8]; n++; end
      e_pre = 0; e_hdr = 0; e_pay = 0; e_pad = 0; e_fcs = 0;
      for (int i = 0; i < 2 * n && i < cap_n && i < MAXN; i++) begin
         en = i[0] ? exp_b[i/2][7:4] : exp_b[i/2][3:0];
         if (cap[i] !== en) begin
            if (i/2 < 8) e_pre++;
            else if (i/2 < 22) e_hdr++;
            else if (i/2 < 22 + L) e_pay++;
            else if (i/2 < n - 4) e_pad++;
            else e_fcs++;
         end
      end
      chk(cap_n == 2 * n, "R6", "nibbles with enable high", cap_n, 2 * n);
      chk(rise_n == r0 + 1, "R6", "enable runs per frame", rise_n - r0, 1);
      chk(e_pre == 0, "R2", "preamble/delimiter nibble mismatches", e_pre, 0);
      chk(e_hdr == 0, "R3", "header nibble mismatches", e_hdr, 0);
      chk(e_pay == 0, "R1", "payload nibble mismatches", e_pay, 0);
      chk(e_pad == 0, "R5", "pad nibble mismatches", e_pad, 0);
      chk(e_fcs == 0, "R4", "check sequence nibble mismatches", e_fcs, 0);
      chk(acc_n == L, "R9", "bytes accepted", acc_n, L);
      if (b2b) chk(last_gap == IFG, "R8", "gap before frame", last_gap, IFG);
      if (poke) begin
         // R10: a start inside the gap is dropped as well
         start_i = 1'b1;
         @(posedge clk); #1;
         start_i = 1'b0;
         r0 = rise_n;
         repeat (40) @(posedge clk);
         #1;
         chk(rise_n == r0, "R10", "frames from starts while busy", rise_n - r0, 0);
         chk(busy_o === 1'b0, "R11", "busy after gap", busy_o, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL R6 watchdog expired: actual %0d expected %0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] got;
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(mii_txen_o === 1'b0 && mii_txd_o === 4'h0, "R6", "reset outputs",
          {mii_txen_o, mii_txd_o}, 0);
      chk(busy_o === 1'b0, "R11", "busy after reset", busy_o, 0);
      chk(pay_ready_o === 1'b0, "R9", "ready after reset", pay_ready_o, 0);

      // known frame with literal check bytes (R4)
      for (int i = 1; i <= 46; i++) pay_mem[i-1] = 8'(((i / 10) << 4) | (i % 10));
      run_frame(48'hFFFF_FFFF_FFFF, 48'h5800_E35B_E841, 16'h002E, 46, 1'b0, 1'b0);
      got = {cap[2*68+1], cap[2*68], cap[2*69+1], cap[2*69],
             cap[2*70+1], cap[2*70], cap[2*71+1], cap[2*71]};
      chk(got == 32'hCFC7_1FCC, "R4", "known frame check bytes", got, 32'hCFC7_1FCC);

      // sweep of payload lengths, back to back (R1 R5 R8 R9)
      for (int L = 1; L <= 60; L++) begin
         for (int i = 0; i < L; i++) pay_mem[i] = 8'((i * 37 + L * 11) & 8'hFF);
         run_frame(48'h0200_0000_0000 | 48'(L * 48'h0001_0203), 48'h0011_2233_4455 ^ 48'(L),
                   16'(L), L, 1'b0, 1'b1);
      end

      // starts while busy (R10)
      for (int i = 0; i < 20; i++) pay_mem[i] = 8'(8'hA0 + i);
      run_frame(48'h0123_4567_89AB, 48'hCDEF_0123_4567, 16'h0800, 20, 1'b1, 1'b1);

      // long payload
      for (int i = 0; i < 100; i++) pay_mem[i] = 8'(255 - i);
      run_frame(48'hFFFF_FFFF_FFFF, 48'h0A0B_0C0D_0E0F, 16'h0064, 100, 1'b0, 1'b0);

      chk(zero_err == 0, "R6", "nonzero data with enable low", zero_err, 0);
      chk(busy_err == 0, "R11", "enable high with busy low", busy_err, 0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule